// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Access Controller

This block sits between a single-request synchronous bus and an external asynchronous static RAM of 131,072 words by 16 bits. A requester raises a one-cycle strobe with a write flag, a 17-bit word address, 16-bit write data and a 2-bit lane mask. The controller then runs one memory cycle on the active-low pins: chip enable, write enable, output enable and one enable per byte lane. It answers with a one-cycle done pulse and, for reads, the returned word.

The memory data bus is bidirectional. The controller does not use a tristate port. It presents the outgoing word on `mem_dq_o`, a drive-enable on `mem_dq_oe` for the pad buffer, and takes the pin value back on `mem_dq_i`. The length of the strobe is `ACCESS_CYCLES` clock cycles. That count times the clock period must cover the 10 ns address-to-data time, and one more cycle is left before the data is registered.

The sequencer has five states. `ST_IDLE` waits for a request. `ST_SETUP` presents the address with chip enable low and both strobes high. `ST_STROBE` holds write enable or output enable low for `ACCESS_CYCLES` cycles. `ST_RECOVER` raises the strobe with the address still held and pulses done. `ST_SKIP` pulses done for a request whose mask is zero. Five transitions connect them:
- idle to setup, on a request with a non-zero mask.
- idle to skip, on a request with a zero mask.
- setup to strobe, always.
- strobe to recover, when the strobe count ends.
- recover or skip back to idle.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are 1, `mem_dq_oe` is 0 and `rsp_done` is 0.
- R2: A write with mask 11 drives `mem_ce_n` and `mem_we_n` low and stores all 16 bits of `req_wdata` at `req_addr`.
- R3: A read drives `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high. It returns the stored word on `rsp_rdata`, valid in the cycle where `rsp_done` is 1.
- R4: Mask bit 0 drives `mem_be_n[0]` low and selects data bits 7:0. Mask bit 1 drives `mem_be_n[1]` low and selects bits 15:8. A write with one lane enabled leaves the other lane's stored byte unchanged.
- R5: On a read, the bits of `rsp_rdata` in a lane whose mask bit is 0 are returned as zero.
- R6: `mem_dq_oe` is 1 only in cycles where `mem_we_n` is 0. It is 0 in the cycle before write enable falls and in the cycle after it rises.
- R7: While `mem_we_n` is 0, `mem_addr`, `mem_be_n` and `mem_dq_o` are stable. Write enable falls one cycle after chip enable and the address are presented, and it rises one cycle before the controller returns to idle.
- R8: The strobe (`mem_we_n` or `mem_oe_n` low) lasts exactly `ACCESS_CYCLES` cycles. `rsp_done` is a single-cycle pulse that arrives `ACCESS_CYCLES`+2 cycles after the accepting clock edge.
- R9: A request with mask 00 gives a done pulse in the cycle after acceptance. It keeps every memory control high and leaves memory contents unchanged.
- R10: A request is accepted only in idle. A request strobe raised during an access is ignored and does not change the stored data.
- R11: All 17 address bits reach `mem_addr`, including address 0x1FFFF.
- R12: `mem_we_n` and `mem_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 lower lane |
| mem_dq_o | output | 16 | Data toward the memory pins |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data read back from the memory pins |

## Verification
The bench targets single-lane writes. A controller that enabled both lanes would overwrite the neighbouring byte, and the next full-word read would show it. Single-lane reads are given a memory model that returns a known junk pattern on disabled lanes, so a missing zero mask shows up directly in the read data. A zero-mask request is watched cycle by cycle: a design that started a memory cycle anyway would pull chip enable low or corrupt the word. A strobe raised mid-access with a different address and data would, if wrongly accepted, either overwrite that second address or stretch the latency. The bench also counts the strobe cycles and the done latency, and it checks that the driver enable never appears outside the write pulse.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_STROBE  = 3'd2,
        ST_RECOVER = 3'd3,
        ST_SKIP    = 3'd4
    } seq_state_t;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/sram_req_capture.sv
module sram_req_capture #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0]  in_mask,
    output logic              q_write,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic [LANES-1:0]  q_mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_mask  <= '0;
        end else if (accept) begin
            q_write <= in_write;
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
            q_mask  <= in_mask;
        end
    end

    // Captured fields never move while the sequencer is busy (R7, R10)
    p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(q_addr) && $stable(q_wdata) && $stable(q_mask));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ACCESS_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mask_zero,
    input  logic op_write,
    output logic accept,
    output logic chip_active,
    output logic we_act,
    output logic oe_act,
    output logic drive_en,
    output logic capture,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(ACCESS_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCESS_CYCLES - 1);

    seq_state_t state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic last_beat;

    assign last_beat = (cnt == CNT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = mask_zero ? ST_SKIP : ST_SETUP;
                end
            end
            ST_SETUP: begin
                state_nx = ST_STROBE;
                cnt_nx   = '0;
            end
            ST_STROBE: begin
                if (last_beat) begin
                    state_nx = ST_RECOVER;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_RECOVER: state_nx = ST_IDLE;
            ST_SKIP:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        accept      = 1'b0;
        chip_active = 1'b0;
        we_act      = 1'b0;
        oe_act      = 1'b0;
        drive_en    = 1'b0;
        capture     = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE:    accept = req_valid;
            ST_SETUP:   chip_active = 1'b1;
            ST_STROBE: begin
                chip_active = 1'b1;
                we_act      = op_write;
                oe_act      = !op_write;
                drive_en    = op_write;
                capture     = !op_write && last_beat;
            end
            ST_RECOVER: begin
                chip_active = 1'b1;
                done        = 1'b1;
            end
            ST_SKIP:    done = 1'b1;
            default:    ;
        endcase
    end

    // Counter never exceeds the programmed strobe length (R8)
    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

    // A zero-mask request leaves chip enable off and completes next cycle (R9)
    p_zero_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept && mask_zero |=> done && !chip_active);

    // Strobe only ever follows a setup cycle with chip enable (R7)
    p_setup_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_act) |-> $past(chip_active) && !$past(we_act));

endmodule

// File: rtl/sram_lane_unit.sv
module sram_lane_unit
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chip_active,
    input  logic                    capture,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES-1:0]        be_n,
    output logic [LANES*LANE_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_n[g] = !(chip_active && mask[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[g*LANE_W +: LANE_W] <= mask[g] ? dq_in[g*LANE_W +: LANE_W]
                                                     : '0;
            end
        end

        // A lane left out of a read returns zero (R5)
        p_zero_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
            capture && !mask[g] |=> rdata[g*LANE_W +: LANE_W] == '0);
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned ACCESS_CYCLES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/LANE_W-1:0] req_mask,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_done,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_ce_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/LANE_W-1:0] mem_be_n,
    output logic [DATA_W-1:0]        mem_dq_o,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_i
);

    localparam int unsigned LANES = DATA_W / LANE_W;

    logic             accept, chip_active, we_act, oe_act, drive_en, capture;
    logic             op_write;
    logic [LANES-1:0] op_mask;

    sram_req_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .in_write (req_write),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_mask  (req_mask),
        .q_write  (op_write),
        .q_addr   (mem_addr),
        .q_wdata  (mem_dq_o),
        .q_mask   (op_mask)
    );

    sram_seq_fsm #(
        .ACCESS_CYCLES (ACCESS_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .mask_zero   (req_mask == '0),
        .op_write    (op_write),
        .accept      (accept),
        .chip_active (chip_active),
        .we_act      (we_act),
        .oe_act      (oe_act),
        .drive_en    (drive_en),
        .capture     (capture),
        .done        (rsp_done)
    );

    sram_lane_unit #(
        .LANES (LANES)
    ) u_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_active (chip_active),
        .capture     (capture),
        .mask        (op_mask),
        .dq_in       (mem_dq_i),
        .be_n        (mem_be_n),
        .rdata       (rsp_rdata)
    );

    assign mem_ce_n  = !chip_active;
    assign mem_we_n  = !we_act;
    assign mem_oe_n  = !oe_act;
    assign mem_dq_oe = drive_en;

    // Pad driver only while write enable is low (R6)
    p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n && !mem_ce_n);

    // Driver off in the cycle before write enable falls (R6)
    p_release_before_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !$past(mem_dq_oe));

    // Driver off once write enable has risen (R6)
    p_release_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    // Address, lanes and data frozen across the write pulse (R7)
    p_pulse_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n && $past(!mem_we_n) |->
            $stable(mem_addr) && $stable(mem_be_n) && $stable(mem_dq_o));

    // Write enable rises while chip enable is still held (R7)
    p_we_rise_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n);

    // Done lasts a single cycle (R8)
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // Read and write strobes exclusive (R12)
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // Deselected means no strobe and no lane enable (R1)
    p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> mem_we_n && mem_oe_n && (&mem_be_n));

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

    localparam int AC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_done;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_o, mem_dq_i;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(.ACCESS_CYCLES(AC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // Small memory model: low 8 address bits select a word
    logic [15:0] ram [256];
    initial for (int i = 0; i < 256; i++) ram[i] = 16'h0000;

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_be_n[0]) ram[mem_addr[7:0]][7:0]  <= mem_dq_oe ? mem_dq_o[7:0]  : 8'hEE;
            if (!mem_be_n[1]) ram[mem_addr[7:0]][15:8] <= mem_dq_oe ? mem_dq_o[15:8] : 8'hEE;
        end
    end

    always_comb begin
        mem_dq_i = 16'hA5C3;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            mem_dq_i[7:0]  = mem_be_n[0] ? 8'hC3 : ram[mem_addr[7:0]][7:0];
            mem_dq_i[15:8] = mem_be_n[1] ? 8'hA5 : ram[mem_addr[7:0]][15:8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Results of the last access
    int          lat, strobes;
    logic        hold_bad, drive_bad, order_bad, ce_seen, addr_hi_ok;
    logic [15:0] rdat;

    task automatic access(input logic wr, input logic [16:0] a,
                          input logic [15:0] d, input logic [1:0] m);
        logic prev_we, prev_ce;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; strobes = 0; hold_bad = 0; drive_bad = 0; order_bad = 0;
        ce_seen = 0; addr_hi_ok = 1; prev_we = 1; prev_ce = 1;
        while (!rsp_done && lat < 40) begin
            if (!mem_ce_n) begin
                ce_seen = 1;
                if (mem_addr !== a) addr_hi_ok = 0;
            end
            if (!mem_we_n || !mem_oe_n) begin
                strobes++;
                if (mem_addr !== a || mem_be_n !== ~m) hold_bad = 1;
            end
            if (!mem_we_n && mem_dq_o !== d) hold_bad = 1;
            if (mem_dq_oe && mem_we_n) drive_bad = 1;
            if (!mem_we_n && prev_we && prev_ce) order_bad = 1;
            prev_we = mem_we_n; prev_ce = mem_ce_n;
            @(negedge clk);
            lat++;
        end
        if (mem_dq_oe || !mem_we_n || !mem_oe_n) drive_bad = 1;
        rdat = rsp_rdata;
        @(negedge clk);
        if (rsp_done) lat = 99;
    endtask

    task automatic t_reset();
        chk("R1 ce_n/we_n/oe_n", {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h7);
        chk("R1 be_n", {30'd0, mem_be_n}, 32'h3);
        chk("R1 dq_oe/done", {30'd0, mem_dq_oe, rsp_done}, 32'h0);
    endtask

    task automatic t_full_word();
        access(1'b1, 17'h00010, 16'hBEEF, 2'b11);
        chk("R2 word stored", ram[8'h10], 16'hBEEF);
        chk("R8 write latency", lat, AC + 2);
        chk("R8 write strobe length", strobes, AC);
        chk("R6 drive only in pulse", drive_bad, 0);
        chk("R7 hold during pulse", hold_bad, 0);
        chk("R7 setup before pulse", order_bad, 0);
        access(1'b0, 17'h00010, 16'h0000, 2'b11);
        chk("R3 read word", rdat, 16'hBEEF);
        chk("R8 read latency", lat, AC + 2);
        chk("R8 read strobe length", strobes, AC);
        chk("R12 no overlap on read", drive_bad, 0);
    endtask

    task automatic t_high_addr();
        access(1'b1, 17'h1FFFF, 16'h1357, 2'b11);
        chk("R11 address on pins", addr_hi_ok, 1);
        access(1'b0, 17'h1FFFF, 16'h0000, 2'b11);
        chk("R11 read high address", rdat, 16'h1357);
    endtask

    task automatic t_lane_write();
        access(1'b1, 17'h00020, 16'h1234, 2'b11);
        access(1'b1, 17'h00020, 16'hFF99, 2'b01);
        access(1'b0, 17'h00020, 16'h0000, 2'b11);
        chk("R4 lower lane only", rdat, 16'h1299);
        access(1'b1, 17'h00020, 16'h77FF, 2'b10);
        access(1'b0, 17'h00020, 16'h0000, 2'b11);
        chk("R4 upper lane only", rdat, 16'h7799);
    endtask

    task automatic t_lane_read();
        access(1'b0, 17'h00020, 16'h0000, 2'b01);
        chk("R5 upper lane zero", rdat, 16'h0099);
        access(1'b0, 17'h00020, 16'h0000, 2'b10);
        chk("R5 lower lane zero", rdat, 16'h7700);
    endtask

    task automatic t_zero_mask();
        access(1'b1, 17'h00030, 16'h4444, 2'b11);
        access(1'b1, 17'h00030, 16'hDEAD, 2'b00);
        chk("R9 done next cycle", lat, 1);
        chk("R9 chip enable untouched", ce_seen, 0);
        chk("R9 memory unchanged", ram[8'h30], 16'h4444);
    endtask

    task automatic t_busy_ignore();
        access(1'b1, 17'h00041, 16'h7777, 2'b11);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00040;
        req_wdata = 16'h1111; req_mask = 2'b11;
        @(negedge clk);
        req_addr = 17'h00041; req_wdata = 16'h2222;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        lat = 3;
        while (!rsp_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R10 latency unchanged", lat, AC + 2);
        @(negedge clk);
        chk("R10 no second start", {31'd0, mem_ce_n}, 1);
        access(1'b0, 17'h00041, 16'h0000, 2'b11);
        chk("R10 busy request ignored", rdat, 16'h7777);
        access(1'b0, 17'h00040, 16'h0000, 2'b11);
        chk("R10 first request kept", rdat, 16'h1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_word();
        t_high_addr();
        t_lane_write();
        t_lane_read();
        t_zero_mask();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule